// File: doc/BRIEF.md
# Gated-Window Frequency Counter

This block measures the frequency of an asynchronous digital test signal against a fixed system clock. A phase counter splits time into a long counting window and a short dead gap that repeat without pause. While the window is open, each rising edge of the synchronized test signal adds one to an accumulator. In the gap, the accumulator's value moves into an output register. A one-cycle strobe marks the new value, and the accumulator clears so that the next window starts from zero.

With the default parameters (10 MHz clock, 100,000-cycle window, 3-cycle gap) the window lasts 10 ms. The frequency in hertz is then the reported count times 100. The accumulator stops at a parameterized ceiling instead of wrapping. By default the ceiling is half the window length, the highest edge rate the synchronizer can resolve.

Top module: `freq_counter`

## Requirements
- R1: While the synchronous reset `rst` is high, `count` is 0 and `update` is 0. The first window starts on the first clock edge after `rst` falls, so the first `update` is seen HIGH_CYCLES+1 cycles after release.
- R2: The window/gap sequence repeats with a period of exactly HIGH_CYCLES+LOW_CYCLES clock cycles. Consecutive `update` pulses are that far apart.
- R3: Each rising edge of `testIn` that falls well inside a window is counted once. A rising edge here is a low level followed by a high level, each held for at least two clock cycles. The count appears on `count` at the next `update`.
- R4: `update` is high for exactly one cycle per period, in the gap right after the window closes. `count` takes its new value in that same cycle.
- R5: The accumulator is cleared in every gap. A window with no rising edges reports 0, even when the previous window saturated.
- R6: When more than SAT_LIMIT edges arrive in one window, the reported count is SAT_LIMIT.
- R7: `count` holds its value in every cycle in which `update` is low.
- R8: A level held high counts as one edge only. A window in which `testIn` stays high throughout reports 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| testIn | input | 1 | Asynchronous signal under measurement |
| count | output | CNT_W | Edge count captured from the last completed window |
| update | output | 1 | One-cycle strobe marking a new `count` |

## Verification
Assertions check on every cycle that:
- the phase counter stays within its period;
- the capture strobe never overlaps the counting window;
- the accumulator never passes its ceiling and reads zero after a clear;
- `count` is stable whenever `update` is low;
- `update` never lasts two cycles.

Only the directed scenarios can show that the number reported equals the number of edges driven. The same holds for the exact spacing of `update` pulses after reset and in steady state, saturation under a full-rate toggle, and a held-high level being counted once.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef struct packed {
    logic countEn;
    logic capture;
    logic clear;
  } ctrlStrobe_t;
endpackage

// File: rtl/freq_gate_ctrl.sv
module freq_gate_ctrl
  import fc_pkg::*;
#(
  parameter int HIGH_CYCLES = 100000,
  parameter int LOW_CYCLES  = 3
) (
  input  logic        clk,
  input  logic        rst,
  output ctrlStrobe_t strb
);
  localparam int PERIOD = HIGH_CYCLES + LOW_CYCLES;
  localparam int PH_W   = $clog2(PERIOD);
  localparam logic [PH_W-1:0] HIGH_IDX = PH_W'(HIGH_CYCLES);
  localparam logic [PH_W-1:0] LAST_IDX = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (rst)                   phaseCnt <= '0;
    else if (phaseCnt == LAST_IDX) phaseCnt <= '0;
    else                       phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    strb.countEn = (phaseCnt < HIGH_IDX);
    strb.capture = (phaseCnt == HIGH_IDX);
    strb.clear   = (phaseCnt == LAST_IDX);
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phaseCnt <= LAST_IDX);

  // R4
  capture_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
    strb.capture |-> !strb.countEn);

  // R2
  wrap_to_window_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> strb.countEn);
endmodule

// File: rtl/freq_count_dp.sv
module freq_count_dp
  import fc_pkg::*;
#(
  parameter int SAT_LIMIT   = 50000,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(SAT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             testIn,
  input  ctrlStrobe_t      strb,
  output logic [CNT_W-1:0] count,
  output logic             update
);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(SAT_LIMIT);

  // syncChain[0..SYNC_STAGES-1] synchronize; top bit keeps the prior sample
  logic [SYNC_STAGES:0] syncChain;
  logic                 risePulse;
  logic [CNT_W-1:0]     acc;

  always_ff @(posedge clk) begin
    if (rst) syncChain <= '0;
    else     syncChain <= {syncChain[SYNC_STAGES-1:0], testIn};
  end

  assign risePulse = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (strb.clear)
      acc <= '0;
    else if (strb.countEn && risePulse && (acc != SAT_VAL))
      acc <= acc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      update <= 1'b0;
    end else begin
      update <= strb.capture;
      if (strb.capture) count <= acc;
    end
  end

  // R6
  acc_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    acc <= SAT_VAL);

  // R5
  acc_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> (acc == '0));

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !update |-> $stable(count));

  // R4
  update_single_chk: assert property (@(posedge clk) disable iff (rst)
    update |=> !update);
endmodule

// File: rtl/freq_counter.sv
module freq_counter
  import fc_pkg::*;
#(
  parameter int HIGH_CYCLES = 100000,
  parameter int LOW_CYCLES  = 3,
  parameter int SAT_LIMIT   = HIGH_CYCLES / 2,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(SAT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             testIn,
  output logic [CNT_W-1:0] count,
  output logic             update
);
  ctrlStrobe_t strb;

  freq_gate_ctrl #(
    .HIGH_CYCLES(HIGH_CYCLES),
    .LOW_CYCLES (LOW_CYCLES)
  ) u_ctrl (
    .clk (clk),
    .rst (rst),
    .strb(strb)
  );

  freq_count_dp #(
    .SAT_LIMIT  (SAT_LIMIT),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .testIn(testIn),
    .strb  (strb),
    .count (count),
    .update(update)
  );
endmodule

// File: tb/freq_counter_tb.sv
module freq_counter_tb;
  localparam int HIGH = 200;
  localparam int LOW  = 3;
  localparam int SAT  = 40;
  localparam int CW   = $clog2(SAT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic testIn = 1'b0;
  logic [CW-1:0] count;
  logic update;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  freq_counter #(
    .HIGH_CYCLES(HIGH), .LOW_CYCLES(LOW), .SAT_LIMIT(SAT)
  ) u_dut (
    .clk(clk), .rst(rst), .testIn(testIn), .count(count), .update(update)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitUpdate(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!update && cycles < 1000);
    if (!update) chk(1'b0, "timeout", cycles, 0);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      testIn = 1'b1; repeat (2) @(negedge clk);
      testIn = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(count == 0, "R1 count in reset", int'(count), 0);
    chk(update == 0, "R1 update in reset", int'(update), 0);
  endtask

  task automatic testPeriodFromReset();
    int c;
    rst = 1'b0;
    waitUpdate(c);
    chk(c == HIGH + 1, "R1 first update delay", c, HIGH + 1);
    chk(count == 0, "R5 idle window", int'(count), 0);
    waitUpdate(c);
    chk(c == HIGH + LOW, "R2 update spacing", c, HIGH + LOW);
    @(negedge clk);
    chk(update == 0, "R4 update one cycle", int'(update), 0);
  endtask

  // called right after an update has been seen
  task automatic runCount(input int n);
    int c;
    logic [CW-1:0] held;
    held = count;
    repeat (10) @(negedge clk);
    pulses(n);
    chk(count == held, "R7 count stable mid-window", int'(count), int'(held));
    waitUpdate(c);
    chk(count == n, "R3 edge count", int'(count), n);
  endtask

  task automatic testHold();
    int c;
    repeat (10) @(negedge clk);
    pulses(3);
    testIn = 1'b1;
    waitUpdate(c);
    chk(count == 4, "R8 hold counted once", int'(count), 4);
    waitUpdate(c);
    chk(count == 0, "R8 held-high window", int'(count), 0);
    testIn = 1'b0;
  endtask

  task automatic testSaturate();
    int c;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 180; i++) begin
      testIn = ~testIn;
      @(negedge clk);
    end
    testIn = 1'b0;
    waitUpdate(c);
    chk(count == SAT, "R6 saturation", int'(count), SAT);
    waitUpdate(c);
    chk(count == 0, "R5 clear after saturation", int'(count), 0);
  endtask

  task automatic testMidReset();
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(count == 0, "R1 mid-run reset count", int'(count), 0);
    chk(update == 0, "R1 mid-run reset update", int'(update), 0);
    testPeriodFromReset();
  endtask

  initial begin
    int c;
    testReset();
    testPeriodFromReset();
    runCount(5);
    runCount(20);
    runCount(0);
    runCount(1);
    testHold();
    testSaturate();
    runCount(7);
    testMidReset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule